// File: doc/BRIEF.md
# Eight-Channel DAC Host Register Front End

This block sits between a narrow I/O-mapped host bus and a bank of eight 12-bit digital-to-analog converters that share one parallel load port. It claims a 32-byte window whose position is set by a five-bit base-select input compared against the upper address bits. Host word writes place converter codes into per-channel holding registers. A small sequencer then sends each pending code to the shared port one channel at a time: it places the channel number and code on the port and then drives an active-low load strobe.

The same window also holds a control byte, an interrupt-enable byte, a command that sets every channel to its lowest code, and an address that acknowledges an interrupt. The control byte carries the converter reference enable and the stop bit for an external counter chain. The interrupt source is the output of an external counter. The block synchronizes it, detects its falling edges, and keeps a single pending flag. While that flag is set, further edges have no effect until software acknowledges it.

Top module: `dac_bus_regif`

## Requirements
- R1: An access hits only when `bus_addr[9:5]` equals `base_sel`; writes outside the window change no state and start no transfer, and reads outside it return 0.
- R2: A word write (`bus_word`=1) to even offset 2*i (i = 0..7) loads channel i with `bus_wdata[11:0]`; bits 15:12 are ignored, and a byte write (`bus_word`=0) to a channel offset is ignored.
- R3: Offset 0x10 bit 6 drives `ref_en`, which resets to 0 and reads back at bit 6. While it is 0 the converter reference is off, so every analog output is forced to zero.
- R4: Offset 0x10 bit 1 drives `ctr_stop` (1 = counter chain halted, 0 = counting). It resets to 0 and reads back at bit 1; the other bits of a 0x10 read are 0.
- R5: Offset 0x11 is an 8-bit interrupt-enable register that resets to 0x00 and reads back its value. Bit 1 enables the counter interrupt.
- R6: A write of any value to offset 0x13 sets all eight channels to code 0x000, and a transfer of code 0x000 follows for each channel in ascending channel order.
- R7: For each transfer, `dac_chan` and `dac_data` are valid one cycle before `dac_load_n` falls. `dac_load_n` stays low for exactly PULSE_CYC cycles, and the channel and code do not change while it is low.
- R8: A write that arrives while a transfer is in progress is held per channel. Pending channels go out lowest index first, each once, carrying the most recently written code.
- R9: `irq` sets when a falling edge of `cnt0_out`, after an input synchronizer, occurs while enable bit 1 is 1. Edges that occur while the bit is 0 never set it.
- R10: Once set, `irq` stays high through further edges until a write of any value to offset 0x1E clears it in the next cycle.
- R11: A read returns its byte on `bus_rdata` in the cycle after `bus_rd`. Undefined offsets read 0x00, writes to them are ignored, and `bus_rdata` is 0x00 in cycles that do not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_sel | input | 5 | Window base, compared with address bits 9:5 |
| bus_addr | input | 10 | Host I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| cnt0_out | input | 1 | Asynchronous output of the external counter |
| irq | output | 1 | Pending interrupt request |
| ref_en | output | 1 | Converter reference enable |
| ctr_stop | output | 1 | Counter chain stop (1 = halted) |
| dac_data | output | 12 | Code on the shared converter port |
| dac_chan | output | 3 | Channel address on the shared converter port |
| dac_load_n | output | 1 | Active-low load strobe |

## Verification
The bench builds the block with PULSE_CYC = 3 and SYNC_STAGES = 2, and base_sel = 5'b11000, which places the window at 0x300. A strobe longer than one cycle lets the checks on strobe width and on the channel and code holding steady while the strobe is low see more than a single cycle. It also leaves a gap long enough for three host writes, to two different channels, to land while one transfer is still in flight, which exercises both the lowest-index-first order and the rule that a newer code replaces an older one. The two-stage synchronizer sets how long the bench waits after each counter edge before it samples `irq`.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;

    localparam logic [4:0] OFS_CTRL = 5'h10;
    localparam logic [4:0] OFS_IEN  = 5'h11;
    localparam logic [4:0] OFS_ZERO = 5'h13;
    localparam logic [4:0] OFS_ACK  = 5'h1E;

    localparam int CTRL_REF_BIT  = 6;
    localparam int CTRL_STOP_BIT = 1;
    localparam int IEN_CNT0_BIT  = 1;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SETUP  = 2'd1,
        SQ_STROBE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/dac_regif_decode.sv
module dac_regif_decode #(
    parameter int ADDR_W = 10,
    parameter int WIN_W  = 5,
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int BASE_W = ADDR_W - WIN_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base,
    input  logic              wr,
    input  logic              rd,
    input  logic              word,
    output logic              dac_we,
    output logic [CH_W-1:0]   dac_idx,
    output logic              ctrl_we,
    output logic              ien_we,
    output logic              zero_all,
    output logic              irq_ack,
    output logic              rd_hit,
    output logic              rd_ctrl,
    output logic              rd_ien
);
    import dac_regif_pkg::*;

    localparam logic [WIN_W-1:0] DAC_END = WIN_W'(2 * NUM_CH);

    logic             hit;
    logic [WIN_W-1:0] ofs;

    always_comb begin
        ofs      = addr[WIN_W-1:0];
        hit      = (addr[ADDR_W-1:WIN_W] == base);
        dac_we   = hit && wr && word && !ofs[0] && (ofs < DAC_END);
        dac_idx  = ofs[CH_W:1];
        ctrl_we  = hit && wr && (ofs == OFS_CTRL);
        ien_we   = hit && wr && (ofs == OFS_IEN);
        zero_all = hit && wr && (ofs == OFS_ZERO);
        irq_ack  = hit && wr && (ofs == OFS_ACK);
        rd_hit   = hit && rd;
        rd_ctrl  = rd_hit && (ofs == OFS_CTRL);
        rd_ien   = rd_hit && (ofs == OFS_IEN);
    end

endmodule

// File: rtl/dac_chan_seq.sv
module dac_chan_seq #(
    parameter int NUM_CH    = 8,
    parameter int CODE_W    = 12,
    parameter int PULSE_CYC = 2,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int CNT_W    = $clog2(PULSE_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_idx,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              zero_all,
    output logic [CODE_W-1:0] dac_data,
    output logic [CH_W-1:0]   dac_chan,
    output logic              dac_load_n
);
    import dac_regif_pkg::*;

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_CYC - 1);

    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] shadow;
        logic [NUM_CH-1:0]             dirty;
        seq_state_e                    state;
        logic [CNT_W-1:0]              cnt;
        logic [CH_W-1:0]               chan;
        logic [CODE_W-1:0]             data;
        logic                          load_n;
    } seq_t;

    seq_t seq_d, seq_q;
    logic            found;
    logic [CH_W-1:0] pick;

    // lowest pending channel
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (seq_q.dirty[i]) begin
                found = 1'b1;
                pick  = CH_W'(i);
            end
        end
    end

    always_comb begin
        seq_d = seq_q;
        // transfer engine first, so a same-cycle host write re-marks the channel
        unique case (seq_q.state)
            SQ_IDLE: begin
                if (found) begin
                    seq_d.chan        = pick;
                    seq_d.data        = seq_q.shadow[pick];
                    seq_d.dirty[pick] = 1'b0;
                    seq_d.state       = SQ_SETUP;
                end
            end
            SQ_SETUP: begin
                seq_d.load_n = 1'b0;
                seq_d.cnt    = '0;
                seq_d.state  = SQ_STROBE;
            end
            SQ_STROBE: begin
                if (seq_q.cnt == CNT_LAST) begin
                    seq_d.load_n = 1'b1;
                    seq_d.state  = SQ_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.state = SQ_IDLE;
        endcase
        // host side
        if (zero_all) begin
            seq_d.shadow = '0;
            seq_d.dirty  = '1;
        end else if (wr_en) begin
            seq_d.shadow[wr_idx] = wr_code;
            seq_d.dirty[wr_idx]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q        <= '0;
            seq_q.state  <= SQ_IDLE;
            seq_q.load_n <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign dac_data   = seq_q.data;
    assign dac_chan   = seq_q.chan;
    assign dac_load_n = seq_q.load_n;

endmodule

// File: rtl/dac_irq_ctl.sv
module dac_irq_ctl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_async,
    input  logic enable,
    input  logic ack,
    output logic pend
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   pend;
    } irq_t;

    irq_t irq_d, irq_q;
    logic fall;

    always_comb begin
        irq_d      = irq_q;
        irq_d.sync = {irq_q.sync[SYNC_STAGES-2:0], src_async};
        irq_d.prev = irq_q.sync[SYNC_STAGES-1];
        fall       = irq_q.prev && !irq_q.sync[SYNC_STAGES-1];
        // a qualifying edge outranks a same-cycle acknowledge
        if (fall && enable) begin
            irq_d.pend = 1'b1;
        end else if (ack) begin
            irq_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign pend = irq_q.pend;

endmodule

// File: rtl/dac_bus_regif.sv
module dac_bus_regif #(
    parameter int ADDR_W      = 10,
    parameter int WIN_W       = 5,
    parameter int NUM_CH      = 8,
    parameter int CODE_W      = 12,
    parameter int DATA_W      = 16,
    parameter int PULSE_CYC   = 2,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = $clog2(NUM_CH),
    localparam int BASE_W     = ADDR_W - WIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] base_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_word,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              cnt0_out,
    output logic              irq,
    output logic              ref_en,
    output logic              ctr_stop,
    output logic [CODE_W-1:0] dac_data,
    output logic [CH_W-1:0]   dac_chan,
    output logic              dac_load_n
);
    import dac_regif_pkg::*;

    typedef struct packed {
        logic       ref_en;
        logic       ctr_stop;
        logic [7:0] ien;
        logic [7:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic            dac_we, ctrl_we, ien_we, zero_all, irq_ack;
    logic            rd_hit, rd_ctrl, rd_ien;
    logic [CH_W-1:0] dac_idx;
    logic [7:0]      irq_en_w;

    dac_regif_decode #(
        .ADDR_W (ADDR_W),
        .WIN_W  (WIN_W),
        .NUM_CH (NUM_CH)
    ) u_dec (
        .addr     (bus_addr),
        .base     (base_sel),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .word     (bus_word),
        .dac_we   (dac_we),
        .dac_idx  (dac_idx),
        .ctrl_we  (ctrl_we),
        .ien_we   (ien_we),
        .zero_all (zero_all),
        .irq_ack  (irq_ack),
        .rd_hit   (rd_hit),
        .rd_ctrl  (rd_ctrl),
        .rd_ien   (rd_ien)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rdata = '0;
        if (ctrl_we) begin
            ctl_d.ref_en   = bus_wdata[CTRL_REF_BIT];
            ctl_d.ctr_stop = bus_wdata[CTRL_STOP_BIT];
        end
        if (ien_we) begin
            ctl_d.ien = bus_wdata[7:0];
        end
        if (rd_hit) begin
            if (rd_ctrl) begin
                ctl_d.rdata[CTRL_REF_BIT]  = ctl_q.ref_en;
                ctl_d.rdata[CTRL_STOP_BIT] = ctl_q.ctr_stop;
            end else if (rd_ien) begin
                ctl_d.rdata = ctl_q.ien;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign irq_en_w  = ctl_q.ien;
    assign bus_rdata = ctl_q.rdata;
    assign ref_en    = ctl_q.ref_en;
    assign ctr_stop  = ctl_q.ctr_stop;

    dac_chan_seq #(
        .NUM_CH    (NUM_CH),
        .CODE_W    (CODE_W),
        .PULSE_CYC (PULSE_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (dac_we),
        .wr_idx     (dac_idx),
        .wr_code    (bus_wdata[CODE_W-1:0]),
        .zero_all   (zero_all),
        .dac_data   (dac_data),
        .dac_chan   (dac_chan),
        .dac_load_n (dac_load_n)
    );

    dac_irq_ctl #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_async (cnt0_out),
        .enable    (irq_en_w[IEN_CNT0_BIT]),
        .ack       (irq_ack),
        .pend      (irq)
    );

endmodule

// File: rtl/dac_regif_chk.sv
module dac_regif_chk #(
    parameter int ADDR_W    = 10,
    parameter int WIN_W     = 5,
    parameter int CODE_W    = 12,
    parameter int CH_W      = 3,
    parameter int PULSE_CYC = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-WIN_W-1:0]  base_sel,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic [7:0]               bus_rdata,
    input logic                     irq,
    input logic [7:0]               irq_en_w,
    input logic [CODE_W-1:0]        dac_data,
    input logic [CH_W-1:0]          dac_chan,
    input logic                     dac_load_n
);
    logic       ack_wr;
    logic [7:0] low_cnt;

    assign ack_wr = bus_wr && (bus_addr == {base_sel, 5'h1E});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!dac_load_n) begin
            low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    // R7
    strobe_width_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_load_n |-> (low_cnt < 8'(PULSE_CYC)));

    // R7
    strobe_width_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_load_n) |-> (low_cnt == 8'(PULSE_CYC)));

    // R7
    port_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_load_n |-> ($stable(dac_data) && $stable(dac_chan)));

    // R9
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_en_w[1]));

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_wr) |=> irq);

    // R11
    rdata_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata != 8'h00) |-> $past(bus_rd));

endmodule

bind dac_bus_regif dac_regif_chk #(
    .ADDR_W    (ADDR_W),
    .WIN_W     (WIN_W),
    .CODE_W    (CODE_W),
    .CH_W      (CH_W),
    .PULSE_CYC (PULSE_CYC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_sel   (base_sel),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .irq_en_w   (irq_en_w),
    .dac_data   (dac_data),
    .dac_chan   (dac_chan),
    .dac_load_n (dac_load_n)
);

// File: tb/dac_bus_regif_tb_top.sv
module dac_bus_regif_tb_top;

    localparam int PULSE_CYC = 3;
    localparam logic [4:0] BASE = 5'b11000;
    localparam logic [9:0] WBASE = {BASE, 5'h00};

    // {write word, expected code}
    localparam logic [27:0] VEC [8] = '{
        {16'hF123, 12'h123}, {16'h0800, 12'h800}, {16'hAFFF, 12'hFFF}, {16'h0001, 12'h001},
        {16'h5A5A, 12'hA5A}, {16'h0000, 12'h000}, {16'hC7FE, 12'h7FE}, {16'h3456, 12'h456}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_word = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        cnt0_out = 1'b1;
    logic        irq, ref_en, ctr_stop, dac_load_n;
    logic [11:0] dac_data;
    logic [2:0]  dac_chan;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dac_bus_regif #(.PULSE_CYC(PULSE_CYC), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .base_sel(BASE), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_word(bus_word), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cnt0_out(cnt0_out), .irq(irq), .ref_en(ref_en),
        .ctr_stop(ctr_stop), .dac_data(dac_data), .dac_chan(dac_chan), .dac_load_n(dac_load_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [15:0] d, input logic w);
        bus_addr = a; bus_wdata = d; bus_word = w; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_word = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic grab(output bit seen, output logic [2:0] ch, output logic [11:0] code, output int width);
        seen = 1'b0; ch = '0; code = '0; width = 0;
        for (int t = 0; t < 40 && !seen; t++) begin
            if (!dac_load_n) seen = 1'b1;
            else @(negedge clk);
        end
        if (seen) begin
            ch = dac_chan; code = dac_data;
            while (!dac_load_n && width < 50) begin
                width++;
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit          seen;
        logic [2:0]  ch;
        logic [11:0] code;
        int          width;
        logic [7:0]  rb;
        logic [2:0]  q_ch [3];
        logic [11:0] q_code [3];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R3 ref_en reset", ref_en, 0);
        check("R4 ctr_stop reset", ctr_stop, 0);
        check("R9 irq reset", irq, 0);
        check("R7 load_n idle", dac_load_n, 1);
        rd(WBASE | 10'h10, rb); check("R3 ctrl readback reset", rb, 8'h00);
        rd(WBASE | 10'h11, rb); check("R5 ien readback reset", rb, 8'h00);
        check("R11 rdata idle", bus_rdata, 8'h00);

        // vector walk: one word write per channel
        for (int i = 0; i < 8; i++) begin
            wr(WBASE | 10'(2 * i), VEC[i][27:12], 1'b1);
            grab(seen, ch, code, width);
            check("R2 transfer seen", seen, 1);
            check("R2 channel", ch, i);
            check("R2 code low 12 bits", code, VEC[i][11:0]);
            check("R7 strobe width", width, PULSE_CYC);
        end

        // outside window, byte write to channel, undefined offset: no transfer
        wr({5'b10000, 5'h02}, 16'h0ABC, 1'b1);
        grab(seen, ch, code, width);
        check("R1 write outside window ignored", seen, 0);
        wr(WBASE | 10'h04, 16'h0ABC, 1'b0);
        grab(seen, ch, code, width);
        check("R2 byte write to channel ignored", seen, 0);
        wr(WBASE | 10'h12, 16'h00FF, 1'b0);
        grab(seen, ch, code, width);
        check("R11 undefined write ignored", seen, 0);

        // control and enable registers
        wr(WBASE | 10'h10, 16'h0042, 1'b0);
        @(negedge clk);
        check("R3 ref_en set", ref_en, 1);
        check("R4 ctr_stop set", ctr_stop, 1);
        rd(WBASE | 10'h10, rb); check("R4 ctrl readback", rb, 8'h42);
        wr(WBASE | 10'h10, 16'h00FD, 1'b0);
        rd(WBASE | 10'h10, rb); check("R3 ctrl readback other bits", rb, 8'h40);
        check("R4 ctr_stop cleared", ctr_stop, 0);
        rd({5'b00001, 5'h10}, rb); check("R1 read outside window", rb, 8'h00);
        rd(WBASE | 10'h12, rb); check("R11 undefined read", rb, 8'h00);
        wr(WBASE | 10'h11, 16'h00A5, 1'b0);
        rd(WBASE | 10'h11, rb); check("R5 ien readback", rb, 8'hA5);

        // zero all channels
        wr(WBASE | 10'h13, 16'h1234, 1'b0);
        for (int i = 0; i < 8; i++) begin
            grab(seen, ch, code, width);
            check("R6 zero transfer channel", ch, i);
            check("R6 zero transfer code", code, 12'h000);
        end

        // queued writes during a transfer
        fork
            begin
                wr(WBASE | 10'h04, 16'h0111, 1'b1);
                wr(WBASE | 10'h0A, 16'h0222, 1'b1);
                wr(WBASE | 10'h0A, 16'h0333, 1'b1);
                wr(WBASE | 10'h04, 16'h0444, 1'b1);
            end
            begin
                for (int k = 0; k < 3; k++) begin
                    grab(seen, ch, code, width);
                    q_ch[k] = ch; q_code[k] = code;
                end
            end
        join
        check("R8 first channel", q_ch[0], 2);  check("R8 first code", q_code[0], 12'h111);
        check("R8 second channel", q_ch[1], 2); check("R8 second code", q_code[1], 12'h444);
        check("R8 third channel", q_ch[2], 5);  check("R8 third code", q_code[2], 12'h333);
        grab(seen, ch, code, width);
        check("R8 no extra transfer", seen, 0);

        // interrupt with enable bit 1 set (ien = 0xA5 has bit 1 clear)
        cnt0_out = 1'b0; repeat (8) @(negedge clk);
        check("R9 edge while disabled", irq, 0);
        cnt0_out = 1'b1;
        wr(WBASE | 10'h11, 16'h0002, 1'b0);
        repeat (8) @(negedge clk);
        cnt0_out = 1'b0; repeat (8) @(negedge clk);
        check("R9 irq on enabled falling edge", irq, 1);
        cnt0_out = 1'b1; repeat (8) @(negedge clk);
        cnt0_out = 1'b0; repeat (8) @(negedge clk);
        check("R10 irq held through later edge", irq, 1);
        wr({5'b00111, 5'h1E}, 16'h0000, 1'b0);
        check("R10 ack outside window ignored", irq, 1);
        wr(WBASE | 10'h1E, 16'h00FF, 1'b0);
        check("R10 irq cleared by ack", irq, 0);
        cnt0_out = 1'b1;
        repeat (8) @(negedge clk);
        check("R10 stays clear on rising edge", irq, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule